// File: doc/BRIEF.md
# Decade Counter with One-Hot Decoded Outputs

This block divides its clock by ten and shows the count as ten one-hot outputs. Exactly one output is high at a time, and the high position moves up by one on each rising clock edge. After the last position it wraps back to the first. The count is held in a five-bit twisted-ring (Johnson) register. Each decoded output is the AND of two neighbouring ring bits. Only one ring bit changes per clock, so the decoded outputs cannot glitch.

A carry output gives a square wave at one tenth of the clock rate with 50% duty. It is high for the first half of the cycle and rises when the count wraps to zero. Feeding it into the clock of another stage extends the range by a factor of ten per stage.

A synchronous master reset returns the count to zero. A clock-inhibit input, active high, freezes the state. The number of ring stages is a parameter, and the modulus is twice that number. Any ring pattern outside the legal sequence is cleared to zero on the next enabled clock.

Top module: `decade_johnson`

## Requirements
- R1: With `mrst` high at a rising edge, the next state is count 0: `q` equals 1 (bit 0 set) and `carry` is 1.
- R2: After the first reset, `q` has exactly one bit set at all times.
- R3: With `mrst` low and `inh` low, each rising edge moves the set bit of `q` from bit k to bit k+1. From bit 2*STAGES-1 it moves to bit 0.
- R4: With `mrst` low and `inh` high, `q` and `carry` keep their values across the rising edge.
- R5: `mrst` takes priority over `inh`: with both high, the next state is count 0.
- R6: `carry` is 1 while the count (the index of the set bit of `q`) is below STAGES, and 0 otherwise. This gives 5 high and 5 low for the default.
- R7: `carry` rises only on the edge that brings the count to 0.
- R8: The modulus is 2*STAGES. With STAGES=3 the count runs 0..5 and then wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| mrst | input | 1 | Synchronous master reset, active high |
| inh | input | 1 | Clock inhibit, active high, holds state |
| q | output | 2*STAGES | One-hot decoded count |
| carry | output | 1 | Divided-by-modulus square wave, high for counts 0..STAGES-1 |

## Verification
The bench builds two instances on one clock. The first uses the default STAGES=5 and is driven through a vector table that mixes counting, inhibit, reset and reset-with-inhibit, followed by a long free run. The second uses STAGES=3 and shows a modulus of six. On that instance the carry is high for three counts, which confirms that the decode, wrap and carry positions follow the parameter and not fixed indices.

// File: rtl/decade_johnson.sv
module decade_johnson #(
  parameter int STAGES = 5,
  localparam int OUTS = 2 * STAGES
) (
  input  logic            clk,
  input  logic            mrst,
  input  logic            inh,
  output logic [OUTS-1:0] q,
  output logic            carry
);

  logic [STAGES-1:0] js;
  logic [STAGES-1:0] js_next;

  function automatic logic legal(input logic [STAGES-1:0] v);
    logic [STAGES-1:0] m;
    logic ok;
    m  = '0;
    ok = 1'b0;
    for (int k = 0; k <= STAGES; k++) begin
      if (v == m || v == ~m) ok = 1'b1;
      if (k < STAGES) m[k] = 1'b1;
    end
    return ok;
  endfunction

  assign js_next = legal(js) ? {js[STAGES-2:0], ~js[STAGES-1]} : '0;

  always_ff @(posedge clk) begin
    if (mrst)      js <= '0;
    else if (!inh) js <= js_next;
  end

  assign q[0]      = ~js[STAGES-1] & ~js[0];
  assign q[STAGES] =  js[STAGES-1] &  js[0];

  for (genvar k = 1; k < STAGES; k++) begin : g_dec
    assign q[k]        =  js[k-1] & ~js[k];
    assign q[STAGES+k] = ~js[k-1] &  js[k];
  end

  assign carry = ~js[STAGES-1];

  logic armed;
  always_ff @(posedge clk) begin
    if (mrst) armed <= 1'b1;
    else if (armed !== 1'b1) armed <= 1'b0;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    mrst |=> (q == OUTS'(1) && carry));

  a_r2_onehot: assert property (@(posedge clk) disable iff (mrst || armed !== 1'b1)
    $onehot(q));

  a_r3_advance: assert property (@(posedge clk) disable iff (mrst || armed !== 1'b1)
    !inh |=> q == {$past(q[OUTS-2:0]), $past(q[OUTS-1])});

  a_r4_hold: assert property (@(posedge clk) disable iff (mrst || armed !== 1'b1)
    inh |=> ($stable(q) && $stable(carry)));

  a_r7_carry_rise: assert property (@(posedge clk) disable iff (mrst || armed !== 1'b1)
    $rose(carry) |-> q[0]);

endmodule

// File: tb/decade_johnson_bench.sv
module decade_johnson_bench;
  localparam int PERIOD = 10;
  localparam int OUTS   = 10;
  localparam int NV     = 16;

  // {mrst, inh, expected count[3:0]}
  localparam logic [5:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0}, {1'b0, 1'b0, 4'd1}, {1'b0, 1'b0, 4'd2}, {1'b0, 1'b0, 4'd3},
    {1'b0, 1'b1, 4'd3}, {1'b0, 1'b1, 4'd3}, {1'b0, 1'b0, 4'd4}, {1'b0, 1'b0, 4'd5},
    {1'b0, 1'b0, 4'd6}, {1'b0, 1'b0, 4'd7}, {1'b0, 1'b0, 4'd8}, {1'b0, 1'b0, 4'd9},
    {1'b0, 1'b0, 4'd0}, {1'b0, 1'b0, 4'd1}, {1'b1, 1'b1, 4'd0}, {1'b0, 1'b0, 4'd1}
  };

  logic clk = 1'b0;
  logic mrst = 1'b0, inh = 1'b0, mrst_s = 1'b0, inh_s = 1'b0;
  logic [OUTS-1:0] q;
  logic [5:0] q_s;
  logic carry, carry_s;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  decade_johnson u_decade_johnson (.clk(clk), .mrst(mrst), .inh(inh), .q(q), .carry(carry));
  decade_johnson #(.STAGES(3)) u_small (.clk(clk), .mrst(mrst_s), .inh(inh_s), .q(q_s), .carry(carry_s));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int cnt;
    logic prev_c;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      mrst = VEC[i][5];
      inh  = VEC[i][4];
      step();
      chk(i == 0 ? "R1 reset" : (VEC[i][5] && VEC[i][4]) ? "R5 reset over inhibit" :
          VEC[i][4] ? "R4 hold" : "R3 advance", 32'(q), 32'(OUTS'(1) << VEC[i][3:0]));
      chk("R6 carry", 32'(carry), 32'(VEC[i][3:0] < 5));
    end
    mrst = 1'b1; inh = 1'b0;
    step();
    mrst = 1'b0;
    chk("R1 reset q", 32'(q), 32'd1);
    chk("R1 reset carry", 32'(carry), 32'd1);
    cnt = 0;
    prev_c = carry;
    for (int i = 0; i < 35; i++) begin
      step();
      cnt = (cnt + 1) % 10;
      chk("R3 free run", 32'(q), 32'(OUTS'(1) << cnt));
      chk("R2 onehot", 32'($countones(q)), 32'd1);
      chk("R6 carry run", 32'(carry), 32'(cnt < 5));
      if (!prev_c && carry) chk("R7 carry rise at 0", 32'(cnt), 32'd0);
      prev_c = carry;
    end
    mrst_s = 1'b1;
    step();
    mrst_s = 1'b0;
    chk("R8 small reset", 32'(q_s), 32'd1);
    cnt = 0;
    for (int i = 0; i < 13; i++) begin
      step();
      cnt = (cnt + 1) % 6;
      chk("R8 modulus six", 32'(q_s), 32'(6'(1) << cnt));
      chk("R8 carry half", 32'(carry_s), 32'(cnt < 3));
    end
    inh_s = 1'b1;
    step();
    chk("R4 small hold", 32'(q_s), 32'(6'(1) << cnt));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule